// File: doc/BRIEF.md
# Program Flow Sequencer

This block owns the program counter and the stack pointer of an 8-bit processor with 16-bit addresses. A decoder hands it one flow request at a time: advance, jump, call, return, restart, halt, enable interrupts or disable interrupts. A jump, call or return may be made conditional on one of eight flag tests. The block assembles branch targets from two immediate bytes, moves return addresses to and from a byte-wide stack memory, and keeps an interrupt-enable bit and a halted state.

The block is driven by a state machine with seven named states. `ST_READY` accepts a request or an interrupt. `ST_PUSH_HI` and `ST_PUSH_LO` write the return address one byte per cycle. `ST_POP_LO`, `ST_POP_HI` and `ST_POP_FIN` read it back; the stack memory returns read data one cycle after a read request. `ST_HALT` waits for an interrupt. The transitions are as follows. From `ST_READY`, a taken call, a restart, or an accepted interrupt goes to `ST_PUSH_HI`. A taken return goes to `ST_POP_LO`. Halt goes to `ST_HALT`. Any other request stays in `ST_READY`. The push states run `ST_PUSH_HI` to `ST_PUSH_LO` and back to `ST_READY`. The pop states run `ST_POP_LO`, then `ST_POP_HI`, then `ST_POP_FIN`, and back to `ST_READY`. `ST_HALT` goes to `ST_PUSH_HI` on an interrupt it accepts.

A request is accepted only while `busy_o` is low. An interrupt is taken in `ST_READY` only when no request is offered in the same cycle. In `ST_HALT`, any pending interrupt is taken.

Top module: `flow_sequencer`

## Requirements
- R1: After reset: the program counter is RESET_PC (0000h), the stack pointer is RESET_SP (0100h), interrupts are disabled, the block is not halted, and `busy_o` is low.
- R2: A taken jump (op 1) loads the program counter with {imm_hi, imm_lo} at the edge that accepts it, and leaves the stack pointer unchanged.
- R3: Condition codes (cond_code_i) are 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity odd (P=0), 5 parity even (P=1), 6 sign clear, 7 sign set. The flag bits are flags_i[0]=CY, [1]=P, [2]=Z, [3]=S. With cond_en_i low, the request is unconditional.
- R4: A jump, call or return whose condition is false makes the program counter advance by instr_len_i in one cycle. It does not touch the stack and does not change the stack pointer. Advance (op 0) does the same without a condition.
- R5: A taken call (op 2) writes the high byte of (PC + instr_len_i) at SP-1 and the low byte at SP-2 in two consecutive cycles. It then leaves SP reduced by 2 and the program counter at {imm_hi, imm_lo}. Write and read requests are never active together.
- R6: A taken return (op 3) reads the byte at SP, then the byte at SP+1. It loads the program counter with {second byte, first byte} and adds 2 to SP.
- R7: Restart n (op 4, n = rst_num_i) pushes PC + instr_len_i in the same way as a call, then loads the program counter with n*8.
- R8: Halt (op 5) advances the program counter by instr_len_i and enters the halted state. While halted, requests are ignored and the program counter holds.
- R9: Only a trap, or an interrupt request while interrupts are enabled, leaves the halted state. It pushes the current program counter and loads TRAP_VEC (0024h) or IRQ_VEC (003Ch). The trap has priority.
- R10: Enable (op 6) sets and disable (op 7) clears the interrupt-enable bit. Both advance the program counter by instr_len_i.
- R11: In `ST_READY` with no request offered, a trap is always taken and an interrupt request only while enabled. Taking either clears the interrupt-enable bit. A masked request changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Flow request offered |
| req_op_i | input | 3 | Request kind (0 advance, 1 jump, 2 call, 3 return, 4 restart, 5 halt, 6 enable, 7 disable) |
| cond_en_i | input | 1 | Request is conditional |
| cond_code_i | input | 3 | Condition selector |
| flags_i | input | 4 | Current flags {S, Z, P, CY} |
| imm_lo_i | input | 8 | Low target byte |
| imm_hi_i | input | 8 | High target byte |
| rst_num_i | input | 3 | Restart number |
| instr_len_i | input | 2 | Length of the current instruction in bytes |
| irq_i | input | 1 | Maskable interrupt request |
| trap_i | input | 1 | Non-maskable interrupt request |
| stk_rdata_i | input | 8 | Stack read data, valid the cycle after a read |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| stk_wr_o | output | 1 | Stack write request |
| stk_rd_o | output | 1 | Stack read request |
| stk_addr_o | output | 16 | Stack access address |
| stk_wdata_o | output | 8 | Stack write data |
| busy_o | output | 1 | Not ready for a request |
| halted_o | output | 1 | Halted state |
| inte_o | output | 1 | Interrupt-enable bit |

## Verification
The bench builds the block with its default parameters: 8-bit data, a restart stride of 8, the stack starting at 0100h, and vectors 0024h and 003Ch. With these values every stack byte lands in a 256-byte model memory. That makes it practical to sweep all eight condition codes against all sixteen flag combinations for jump, call and return, and to follow each taken call with a return that must restore the pushed address. Restart is swept over all eight numbers. Halt and interrupt entry are run through both masked and unmasked cases.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [2:0] {
        OP_NEXT = 3'd0,
        OP_JUMP = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RST  = 3'd4,
        OP_HALT = 3'd5,
        OP_EI   = 3'd6,
        OP_DI   = 3'd7
    } flow_op_e;

    typedef enum logic [2:0] {
        ST_READY,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_FIN,
        ST_HALT
    } flow_state_e;

    typedef enum logic [1:0] {
        TGT_IMM,
        TGT_RST,
        TGT_TRAP,
        TGT_IRQ
    } tgt_sel_e;

    // flag bit positions within the flags input
    localparam int FLG_CY = 0;
    localparam int FLG_P  = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_S  = 3;
    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
    import flow_pkg::*;
#(
    parameter int CC_W = 3
) (
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic [CC_W-1:0]      cc_i,
    output logic                 true_o
);
    localparam int NUM_CC = 1 << CC_W;

    logic [NUM_CC-1:0] cond_vec;

    // code pairs test one flag; even code wants 0, odd code wants 1
    for (genvar k = 0; k < NUM_CC; k++) begin : g_cc
        localparam int GRP = (k / 2) % 4;
        localparam int FI  = (GRP == 0) ? FLG_Z  :
                             (GRP == 1) ? FLG_CY :
                             (GRP == 2) ? FLG_P  : FLG_S;
        localparam logic POL = logic'(k % 2);
        assign cond_vec[k] = (flags_i[FI] == POL);
    end

    assign true_o = cond_vec[cc_i];

endmodule

// File: rtl/flow_target_mux.sv
module flow_target_mux
    import flow_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RST_W      = 3,
    parameter int RST_STRIDE = 8,
    parameter int TRAP_VEC   = 'h24,
    parameter int IRQ_VEC    = 'h3C
) (
    input  tgt_sel_e              sel_i,
    input  logic [DATA_W-1:0]     imm_lo_i,
    input  logic [DATA_W-1:0]     imm_hi_i,
    input  logic [RST_W-1:0]      rst_num_i,
    output logic [2*DATA_W-1:0]   target_o
);
    localparam int ADDR_W  = 2 * DATA_W;
    localparam int NUM_RST = 1 << RST_W;

    logic [ADDR_W-1:0] rst_vec [NUM_RST];

    for (genvar n = 0; n < NUM_RST; n++) begin : g_rst
        assign rst_vec[n] = ADDR_W'(n * RST_STRIDE);
    end

    always_comb begin
        unique case (sel_i)
            TGT_IMM:  target_o = {imm_hi_i, imm_lo_i};
            TGT_RST:  target_o = rst_vec[rst_num_i];
            TGT_TRAP: target_o = ADDR_W'(TRAP_VEC);
            TGT_IRQ:  target_o = ADDR_W'(IRQ_VEC);
            default:  target_o = '0;
        endcase
    end

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
    import flow_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RST_W      = 3,
    parameter int CC_W       = 3,
    parameter int LEN_W      = 2,
    parameter int RST_STRIDE = 8,
    parameter int RESET_PC   = 0,
    parameter int RESET_SP   = 'h0100,
    parameter int TRAP_VEC   = 'h24,
    parameter int IRQ_VEC    = 'h3C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid_i,
    input  logic [2:0]            req_op_i,
    input  logic                  cond_en_i,
    input  logic [CC_W-1:0]       cond_code_i,
    input  logic [3:0]            flags_i,
    input  logic [DATA_W-1:0]     imm_lo_i,
    input  logic [DATA_W-1:0]     imm_hi_i,
    input  logic [RST_W-1:0]      rst_num_i,
    input  logic [LEN_W-1:0]      instr_len_i,
    input  logic                  irq_i,
    input  logic                  trap_i,
    input  logic [DATA_W-1:0]     stk_rdata_i,
    output logic [2*DATA_W-1:0]   pc_o,
    output logic [2*DATA_W-1:0]   sp_o,
    output logic                  stk_wr_o,
    output logic                  stk_rd_o,
    output logic [2*DATA_W-1:0]   stk_addr_o,
    output logic [DATA_W-1:0]     stk_wdata_o,
    output logic                  busy_o,
    output logic                  halted_o,
    output logic                  inte_o
);
    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    flow_state_e       state_q, state_d;
    logic [ADDR_W-1:0] pc_q, sp_q, ret_q, tgt_q;
    logic [DATA_W-1:0] lo_q;
    logic              inte_q;

    flow_op_e          op;
    logic              cond_true, taken, int_pend, offered;
    tgt_sel_e          tgt_sel;
    logic [ADDR_W-1:0] tgt_w, pc_adv;

    assign op       = flow_op_e'(req_op_i);
    assign offered  = (state_q == ST_READY) && req_valid_i;
    assign taken    = !cond_en_i || cond_true;
    assign int_pend = trap_i || (irq_i && inte_q);
    assign pc_adv   = pc_q + ADDR_W'(instr_len_i);

    flow_cond_eval #(.CC_W(CC_W)) u_cond (
        .flags_i (flags_i),
        .cc_i    (cond_code_i),
        .true_o  (cond_true)
    );

    always_comb begin
        if (offered)
            tgt_sel = (op == OP_RST) ? TGT_RST : TGT_IMM;
        else if (trap_i)
            tgt_sel = TGT_TRAP;
        else
            tgt_sel = TGT_IRQ;
    end

    flow_target_mux #(
        .DATA_W     (DATA_W),
        .RST_W      (RST_W),
        .RST_STRIDE (RST_STRIDE),
        .TRAP_VEC   (TRAP_VEC),
        .IRQ_VEC    (IRQ_VEC)
    ) u_tgt (
        .sel_i     (tgt_sel),
        .imm_lo_i  (imm_lo_i),
        .imm_hi_i  (imm_hi_i),
        .rst_num_i (rst_num_i),
        .target_o  (tgt_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (req_valid_i) begin
                    case (op)
                        OP_CALL: state_d = taken ? ST_PUSH_HI : ST_READY;
                        OP_RET:  state_d = taken ? ST_POP_LO  : ST_READY;
                        OP_RST:  state_d = ST_PUSH_HI;
                        OP_HALT: state_d = ST_HALT;
                        default: state_d = ST_READY;
                    endcase
                end else if (int_pend) begin
                    state_d = ST_PUSH_HI;
                end
            end
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_READY;
            ST_POP_LO:  state_d = ST_POP_HI;
            ST_POP_HI:  state_d = ST_POP_FIN;
            ST_POP_FIN: state_d = ST_READY;
            ST_HALT:    state_d = int_pend ? ST_PUSH_HI : ST_HALT;
            default:    state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= ADDR_W'(RESET_PC);
            sp_q   <= ADDR_W'(RESET_SP);
            ret_q  <= '0;
            tgt_q  <= '0;
            lo_q   <= '0;
            inte_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_READY: begin
                    if (req_valid_i) begin
                        case (op)
                            OP_JUMP: pc_q <= taken ? tgt_w : pc_adv;
                            OP_CALL, OP_RST: begin
                                pc_q  <= pc_adv;
                                ret_q <= pc_adv;
                                tgt_q <= tgt_w;
                            end
                            OP_EI: begin
                                pc_q   <= pc_adv;
                                inte_q <= 1'b1;
                            end
                            OP_DI: begin
                                pc_q   <= pc_adv;
                                inte_q <= 1'b0;
                            end
                            default: pc_q <= pc_adv;
                        endcase
                    end else if (int_pend) begin
                        ret_q  <= pc_q;
                        tgt_q  <= tgt_w;
                        inte_q <= 1'b0;
                    end
                end
                ST_PUSH_LO: begin
                    pc_q <= tgt_q;
                    sp_q <= sp_q - TWO;
                end
                ST_POP_HI: lo_q <= stk_rdata_i;
                ST_POP_FIN: begin
                    pc_q <= {stk_rdata_i, lo_q};
                    sp_q <= sp_q + TWO;
                end
                ST_HALT: begin
                    if (int_pend) begin
                        ret_q  <= pc_q;
                        tgt_q  <= tgt_w;
                        inte_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        stk_wr_o    = 1'b0;
        stk_rd_o    = 1'b0;
        stk_addr_o  = sp_q;
        stk_wdata_o = ret_q[DATA_W-1:0];
        unique case (state_q)
            ST_PUSH_HI: begin
                stk_wr_o    = 1'b1;
                stk_addr_o  = sp_q - ONE;
                stk_wdata_o = ret_q[ADDR_W-1:DATA_W];
            end
            ST_PUSH_LO: begin
                stk_wr_o   = 1'b1;
                stk_addr_o = sp_q - TWO;
            end
            ST_POP_LO:  stk_rd_o = 1'b1;
            ST_POP_HI: begin
                stk_rd_o   = 1'b1;
                stk_addr_o = sp_q + ONE;
            end
            default: ;
        endcase
    end

    assign pc_o     = pc_q;
    assign sp_o     = sp_q;
    assign busy_o   = (state_q != ST_READY);
    assign halted_o = (state_q == ST_HALT);
    assign inte_o   = inte_q;

    // ---------------- assertions ----------------
    assert_jump_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (offered && op == OP_JUMP && taken) |=>
            (pc_o == $past({imm_hi_i, imm_lo_i})) && $stable(sp_o));

    assert_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (offered && cond_en_i && !cond_true &&
         (op == OP_JUMP || op == OP_CALL || op == OP_RET)) |=>
            (pc_o == $past(pc_o) + $past(ADDR_W'(instr_len_i))) &&
            $stable(sp_o) && !busy_o);

    assert_push_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_LO) |=> (sp_o == $past(sp_o) - TWO));

    assert_wr_rd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_wr_o && stk_rd_o));

    assert_pop_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POP_FIN) |=> (sp_o == $past(sp_o) + TWO));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !trap_i && !(irq_i && inte_o)) |=>
            (halted_o && $stable(pc_o)));

    assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (offered && op == OP_DI) |=> !inte_o);

    assert_int_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_READY && !req_valid_i && int_pend) ||
         (state_q == ST_HALT && int_pend)) |=> (!inte_o && state_q == ST_PUSH_HI));

endmodule

// File: tb/test_flow_sequencer.sv
module test_flow_sequencer;
    localparam logic [15:0] RSP = 16'h0100;
    localparam logic [15:0] TV  = 16'h0024;
    localparam logic [15:0] IV  = 16'h003C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op, cond_code, rst_num;
    logic        cond_en, irq, trap;
    logic [3:0]  flags;
    logic [7:0]  imm_lo, imm_hi, stk_rdata, stk_wdata;
    logic [1:0]  instr_len;
    logic [15:0] pc, sp, stk_addr;
    logic        stk_wr, stk_rd, busy, halted, inte;

    logic [7:0]  mem [256];
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    flow_sequencer i_flow_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .cond_en_i(cond_en), .cond_code_i(cond_code), .flags_i(flags),
        .imm_lo_i(imm_lo), .imm_hi_i(imm_hi), .rst_num_i(rst_num),
        .instr_len_i(instr_len), .irq_i(irq), .trap_i(trap),
        .stk_rdata_i(stk_rdata), .pc_o(pc), .sp_o(sp), .stk_wr_o(stk_wr),
        .stk_rd_o(stk_rd), .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata),
        .busy_o(busy), .halted_o(halted), .inte_o(inte)
    );

    always_ff @(posedge clk) begin
        if (stk_wr) mem[stk_addr[7:0]] <= stk_wdata;
        if (stk_rd) stk_rdata <= mem[stk_addr[7:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_cond(input int c, input logic [3:0] f);
        case (c)
            0: return !f[2];
            1: return  f[2];
            2: return !f[0];
            3: return  f[0];
            4: return !f[1];
            5: return  f[1];
            6: return !f[3];
            default: return f[3];
        endcase
    endfunction

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 20) begin
            @(negedge clk);
            g++;
        end
        if (busy) chk("wait for idle", 1, 0);
    endtask

    task automatic issue(input logic [2:0] op, input logic ce, input logic [2:0] cc,
                         input logic [3:0] f, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [2:0] n, input logic [1:0] len, input bit wait_done);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; cond_en = ce; cond_code = cc; flags = f;
        imm_lo = lo; imm_hi = hi; rst_num = n; instr_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        if (wait_done) wait_idle();
    endtask

    task automatic pulse(input bit is_trap);
        @(negedge clk);
        if (is_trap) trap = 1'b1; else irq = 1'b1;
        @(negedge clk);
        trap = 1'b0; irq = 1'b0;
    endtask

    task automatic chk_pushed(input string tag, input logic [15:0] s, input logic [15:0] r);
        chk({tag, " sp"}, sp, s - 16'd2);
        chk({tag, " high byte"}, mem[8'(s - 16'd1)], r[15:8]);
        chk({tag, " low byte"}, mem[8'(s - 16'd2)], r[7:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] p, s, r, q;
        logic        tk;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; cond_en = 1'b0; cond_code = '0;
        flags = '0; imm_lo = '0; imm_hi = '0; rst_num = '0; instr_len = 2'd1;
        irq = 1'b0; trap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset pc", pc, 16'h0000);
        chk("R1 reset sp", sp, RSP);
        chk("R1 reset inte", inte, 0);
        chk("R1 reset halted", halted, 0);
        chk("R1 reset busy", busy, 0);

        // R2 unconditional jump, R4 advance
        issue(3'd1, 1'b0, 3'd0, 4'h0, 8'h34, 8'h12, 3'd0, 2'd3, 1'b1);
        chk("R2 jump pc", pc, 16'h1234);
        issue(3'd0, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd2, 1'b1);
        chk("R4 advance pc", pc, 16'h1236);

        // R2/R3/R4 conditional jump sweep
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                p = pc; s = sp;
                tk = exp_cond(c, 4'(f));
                issue(3'd1, 1'b1, 3'(c), 4'(f), 8'(c * 16 + f), 8'(8'h40 + c), 3'd0, 2'd3, 1'b1);
                chk(tk ? "R3 R2 taken jump pc" : "R3 R4 untaken jump pc", pc,
                    tk ? {8'(8'h40 + c), 8'(c * 16 + f)} : p + 16'd3);
                chk("R4 jump sp", sp, s);
            end
        end

        // R3/R5/R6 conditional call sweep, each taken call unwound by a return
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                p = pc; s = sp; r = p + 16'd3;
                tk = exp_cond(c, 4'(f));
                issue(3'd2, 1'b1, 3'(c), 4'(f), 8'(c * 16 + f), 8'h50, 3'd0, 2'd3, 1'b1);
                if (tk) begin
                    chk("R5 R3 call pc", pc, {8'h50, 8'(c * 16 + f)});
                    chk_pushed("R5 call", s, r);
                    issue(3'd3, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
                    chk("R6 return pc", pc, r);
                    chk("R6 return sp", sp, s);
                end else begin
                    chk("R4 R3 untaken call pc", pc, r);
                    chk("R4 untaken call sp", sp, s);
                end
            end
        end

        // R3/R6 conditional return sweep
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                p = pc;
                issue(3'd2, 1'b0, 3'd0, 4'h0, 8'(c * 16 + f), 8'h60, 3'd0, 2'd3, 1'b1);
                r = p + 16'd3; s = sp; q = pc;
                tk = exp_cond(c, 4'(f));
                issue(3'd3, 1'b1, 3'(c), 4'(f), 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
                if (tk) begin
                    chk("R6 R3 cond return pc", pc, r);
                    chk("R6 cond return sp", sp, s + 16'd2);
                end else begin
                    chk("R4 R3 untaken return pc", pc, q + 16'd1);
                    chk("R4 untaken return sp", sp, s);
                    issue(3'd3, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
                    chk("R6 unwind return pc", pc, r);
                end
            end
        end

        // R7 restart sweep
        for (int n = 0; n < 8; n++) begin
            p = pc; s = sp; r = p + 16'd1;
            issue(3'd4, 1'b0, 3'd0, 4'h0, 8'hFF, 8'hFF, 3'(n), 2'd1, 1'b1);
            chk("R7 restart pc", pc, 16'(n * 8));
            chk_pushed("R7 restart", s, r);
            issue(3'd3, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
            chk("R7 restart return pc", pc, r);
        end

        // R10 enable / disable
        p = pc;
        issue(3'd6, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
        chk("R10 enable inte", inte, 1);
        chk("R10 enable pc", pc, p + 16'd1);
        issue(3'd7, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
        chk("R10 disable inte", inte, 0);
        chk("R10 disable pc", pc, p + 16'd2);

        // R11 masked request at idle
        p = pc; s = sp;
        pulse(1'b0);
        @(negedge clk);
        chk("R11 masked irq busy", busy, 0);
        chk("R11 masked irq pc", pc, p);
        chk("R11 masked irq sp", sp, s);

        // R11 trap at idle
        pulse(1'b1);
        wait_idle();
        chk("R11 trap pc", pc, TV);
        chk_pushed("R11 trap", s, p);
        issue(3'd3, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
        chk("R11 trap return pc", pc, p);

        // R11 enabled irq at idle
        issue(3'd6, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
        p = pc; s = sp;
        pulse(1'b0);
        wait_idle();
        chk("R11 irq pc", pc, IV);
        chk("R11 irq clears inte", inte, 0);
        chk_pushed("R11 irq", s, p);
        issue(3'd3, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);

        // R8 halt, requests ignored
        p = pc; s = sp;
        issue(3'd5, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b0);
        chk("R8 halted", halted, 1);
        chk("R8 halt pc", pc, p + 16'd1);
        issue(3'd1, 1'b0, 3'd0, 4'h0, 8'h11, 8'h22, 3'd0, 2'd3, 1'b0);
        @(negedge clk);
        chk("R8 jump ignored pc", pc, p + 16'd1);
        chk("R8 still halted", halted, 1);

        // R9 masked irq keeps halt, trap leaves
        pulse(1'b0);
        @(negedge clk);
        chk("R9 masked irq halted", halted, 1);
        chk("R9 masked irq pc", pc, p + 16'd1);
        pulse(1'b1);
        wait_idle();
        chk("R9 trap leaves halt", halted, 0);
        chk("R9 trap pc", pc, TV);
        chk_pushed("R9 trap", s, p + 16'd1);
        issue(3'd3, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);

        // R9 enabled irq leaves halt
        issue(3'd6, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b1);
        p = pc; s = sp;
        issue(3'd5, 1'b0, 3'd0, 4'h0, 8'h00, 8'h00, 3'd0, 2'd1, 1'b0);
        pulse(1'b0);
        wait_idle();
        chk("R9 irq leaves halt", halted, 0);
        chk("R9 irq pc", pc, IV);
        chk("R9 irq clears inte", inte, 0);
        chk_pushed("R9 irq", s, p + 16'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule